// File: doc/BRIEF.md
# Posting List Merge Element

This block combines two ascending streams of posting-list entries into a single ascending output stream. The stream is either their intersection, their union or their difference, selected by a static operation code. Each entry is one 32-bit word made of two 16-bit halves. Before an entry is held for comparison it passes a context filter: its 13 context flags are ANDed with a static mask, and an entry with no surviving flag is consumed and dropped. Two holding registers, one per input lane, feed a document-number comparator. The comparator decides which lanes are consumed, whether an output entry is formed and how that entry's count, tag and context fields are built.

Each input lane and the output use a full/empty interlock. An input lane's full flag belongs to the producer. The block pulses the lane's take output in a cycle where it absorbs the presented entry, and the producer then drops or replaces its data. The output full flag belongs to the block: it sets the flag when it places an entry, and the consumer clears it with a one-cycle clear pulse. A list ends with a sentinel entry whose document number is all ones (0xFFF). The sentinel compares above every real document and is never filtered. The block stops early when the operation allows it, pulses done once the last output has drained, and then stays idle until the next reset.

Top module: `plm_merge_top`

## Requirements
- R1: Entry layout is bits 31..28 context flags high, 27..16 document number, 15 full-text tag, 14..6 context flags low, 5..0 count. The mask input is ordered {high flags, low flags}. An entry whose 13 flags share no set bit with the mask is consumed and has no effect on the output stream. A sentinel entry (document 0xFFF) is always kept.
- R2: With both holding registers full, the lane with the lower document number is consumed. On equal numbers both lanes are consumed. The output document number is the lower of the two.
- R3: Operation code 2'b00 (intersection) emits an entry only on equal document numbers. Its count is the smaller of the two counts, its tag is the OR of the two tags, and all its context flags are zero.
- R4: Operation code 2'b01 (union) emits an entry on every comparison. A lane contributes to the output only when its document number is the lower or equal one. The output count is the saturating sum of the contributing counts, the output tag is the OR of the contributing tags, and the output context flags are the OR of the contributing flags.
- R5: Operation code 2'b10 (difference) emits an entry only when the first lane's document number is strictly lower. That entry equals the first lane's entry.
- R6: The output count saturates at 63 (all ones).
- R7: A lane's take output is asserted only while that lane's full input is high, and each take absorbs exactly one entry.
- R8: Once the output full flag is set, it and the output entry stay unchanged until the consumer pulses clear.
- R9: Intersection ends when either held entry is a sentinel. Difference ends when the first lane holds a sentinel. Union ends when both lanes hold sentinels. After the end, no lane is taken and no entry is emitted.
- R10: Done is a single-cycle pulse. It is raised only after the output register has been emptied by the consumer.
- R11: After reset the output full flag, done and both take outputs are low while the inputs are idle.
- R12: The reserved operation code 2'b11 behaves as union.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation select, static during a run |
| ctx_mask_i | input | 13 | Context mask {high flags, low flags} |
| x_full_i | input | 1 | First lane entry present |
| x_entry_i | input | 32 | First lane entry |
| x_take_o | output | 1 | First lane entry absorbed this cycle |
| y_full_i | input | 1 | Second lane entry present |
| y_entry_i | input | 32 | Second lane entry |
| y_take_o | output | 1 | Second lane entry absorbed this cycle |
| o_full_o | output | 1 | Output entry present |
| o_entry_o | output | 32 | Output entry |
| o_clr_i | input | 1 | Consumer has taken the output entry |
| done_o | output | 1 | Run finished, one-cycle pulse |

## Verification
The bench uses random lists drawn from a shared document pool, so the two lanes overlap partly and are sometimes empty. These lists meet random stalls on both lanes and on the output, and their entries carry flags that the mask sometimes rejects. A design that compared entries before filtering would emit documents that should have been dropped. A design that consumed only one lane on a tie would emit duplicates under union. Directed cases cover lists holding only the sentinel, two counts whose sum overflows (a wrapping adder would give 16 instead of 63), and early stop. In the early-stop cases the other lane still has entries waiting: a design that kept fetching would show takes after done, and one that raised done before the last output drained would lose that entry.

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
package plm_pkg;

   typedef enum logic [1:0] {
      OP_AND    = 2'b00,
      OP_OR     = 2'b01,
      OP_ANDNOT = 2'b10,
      OP_RSVD   = 2'b11
   } plm_op_e;

   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/plm_ctx_filter.sv
`timescale 1ns/1ps
module plm_ctx_filter #(
   parameter int unsigned DOC_W    = 12,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CTX_HI_W = 4,
   parameter int unsigned CTX_LO_W = 9
) (
   input  logic [2*(1+CTX_LO_W+CNT_W)-1:0] entry_i,
   input  logic [CTX_HI_W+CTX_LO_W-1:0]    mask_i,
   output logic                            keep_o
);
   localparam int unsigned WORD_W  = 1 + CTX_LO_W + CNT_W;
   localparam int unsigned ENTRY_W = 2 * WORD_W;
   localparam int unsigned DOC_TOP = ENTRY_W - CTX_HI_W - 1;

   logic [CTX_HI_W+CTX_LO_W-1:0] flags;
   logic                         is_end;

   always_comb begin
      flags  = {entry_i[ENTRY_W-1 -: CTX_HI_W], entry_i[CNT_W +: CTX_LO_W]};
      is_end = &entry_i[DOC_TOP -: DOC_W];
      keep_o = is_end | (|(flags & mask_i));
   end
endmodule

// File: rtl/plm_hold.sv
`timescale 1ns/1ps
module plm_hold #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] d_i,
   output logic             full_o,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         q_o    <= '0;
      end else if (load_i) begin
         full_o <= 1'b1;
         q_o    <= d_i;
      end else if (clr_i) begin
         full_o <= 1'b0;
      end
   end
endmodule

// File: rtl/plm_combine.sv
`timescale 1ns/1ps
module plm_combine import plm_pkg::*; #(
   parameter int unsigned DOC_W    = 12,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CTX_HI_W = 4,
   parameter int unsigned CTX_LO_W = 9,
   parameter bit          SATURATE = 1'b1
) (
   input  plm_op_e                         op_i,
   input  logic [2*(1+CTX_LO_W+CNT_W)-1:0] x_i,
   input  logic [2*(1+CTX_LO_W+CNT_W)-1:0] y_i,
   output logic                            x_low_o,
   output logic                            y_low_o,
   output logic                            emit_o,
   output logic [2*(1+CTX_LO_W+CNT_W)-1:0] out_o
);
   localparam int unsigned WORD_W  = 1 + CTX_LO_W + CNT_W;
   localparam int unsigned ENTRY_W = 2 * WORD_W;
   localparam int unsigned DOC_TOP = ENTRY_W - CTX_HI_W - 1;
   localparam int unsigned TAG_B   = CTX_LO_W + CNT_W;

   logic [DOC_W-1:0]    doc_x, doc_y, doc_lo;
   logic [CNT_W-1:0]    cnt_x, cnt_y, cnt_min, cnt_sum;
   logic [CNT_W:0]      raw_sum;
   logic [CTX_HI_W-1:0] hi_mix;
   logic [CTX_LO_W-1:0] lo_mix;
   logic                tag_mix;

   always_comb begin
      doc_x   = x_i[DOC_TOP -: DOC_W];
      doc_y   = y_i[DOC_TOP -: DOC_W];
      cnt_x   = x_i[CNT_W-1:0];
      cnt_y   = y_i[CNT_W-1:0];
      x_low_o = (doc_x <= doc_y);
      y_low_o = (doc_y <= doc_x);
      doc_lo  = x_low_o ? doc_x : doc_y;
      cnt_min = (cnt_x < cnt_y) ? cnt_x : cnt_y;
      raw_sum = (x_low_o ? {1'b0, cnt_x} : '0) + (y_low_o ? {1'b0, cnt_y} : '0);
      hi_mix  = (x_low_o ? x_i[ENTRY_W-1 -: CTX_HI_W] : '0)
              | (y_low_o ? y_i[ENTRY_W-1 -: CTX_HI_W] : '0);
      lo_mix  = (x_low_o ? x_i[CNT_W +: CTX_LO_W] : '0)
              | (y_low_o ? y_i[CNT_W +: CTX_LO_W] : '0);
      tag_mix = (x_low_o & x_i[TAG_B]) | (y_low_o & y_i[TAG_B]);
   end

   generate
      if (SATURATE) begin : g_sat
         assign cnt_sum = raw_sum[CNT_W] ? {CNT_W{1'b1}} : raw_sum[CNT_W-1:0];
      end else begin : g_wrap
         assign cnt_sum = raw_sum[CNT_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_AND: begin
            emit_o = x_low_o & y_low_o;
            out_o  = {{CTX_HI_W{1'b0}}, doc_lo, x_i[TAG_B] | y_i[TAG_B],
                      {CTX_LO_W{1'b0}}, cnt_min};
         end
         OP_ANDNOT: begin
            emit_o = x_low_o & ~y_low_o;
            out_o  = {hi_mix, doc_lo, tag_mix, lo_mix, cnt_sum};
         end
         default: begin
            emit_o = 1'b1;
            out_o  = {hi_mix, doc_lo, tag_mix, lo_mix, cnt_sum};
         end
      endcase
   end
endmodule

// File: rtl/plm_merge_top.sv
`timescale 1ns/1ps
module plm_merge_top import plm_pkg::*; #(
   parameter int unsigned DOC_W    = 12,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CTX_HI_W = 4,
   parameter int unsigned CTX_LO_W = 9,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [1:0]                      op_i,
   input  logic [CTX_HI_W+CTX_LO_W-1:0]    ctx_mask_i,
   input  logic                            x_full_i,
   input  logic [2*(1+CTX_LO_W+CNT_W)-1:0] x_entry_i,
   output logic                            x_take_o,
   input  logic                            y_full_i,
   input  logic [2*(1+CTX_LO_W+CNT_W)-1:0] y_entry_i,
   output logic                            y_take_o,
   output logic                            o_full_o,
   output logic [2*(1+CTX_LO_W+CNT_W)-1:0] o_entry_o,
   input  logic                            o_clr_i,
   output logic                            done_o
);
   localparam int unsigned WORD_W  = 1 + CTX_LO_W + CNT_W;
   localparam int unsigned ENTRY_W = 2 * WORD_W;
   localparam int unsigned DOC_TOP = ENTRY_W - CTX_HI_W - 1;

   if (DOC_W + CTX_HI_W != WORD_W) begin : g_layout_bad
      $error("plm_merge_top: halves of the entry differ in width");
   end
   if (CNT_W < 2 || DOC_W < 2) begin : g_width_bad
      $error("plm_merge_top: count and document fields need two bits or more");
   end

   plm_op_e                      op_eff;
   logic [NUM_LANES-1:0]         lane_full, lane_keep, lane_take;
   logic [NUM_LANES-1:0]         hold_full, hold_clr, hold_end;
   logic [ENTRY_W-1:0]           lane_entry [NUM_LANES];
   logic [ENTRY_W-1:0]           hold_q     [NUM_LANES];
   logic                         halted_q, term, cmp_go, finish;
   logic                         x_low, y_low, emit;
   logic [ENTRY_W-1:0]           merged;
   logic                         o_full_q;
   logic [ENTRY_W-1:0]           o_entry_q;

   assign op_eff        = (op_i == OP_RSVD) ? OP_OR : plm_op_e'(op_i);
   assign lane_full[0]  = x_full_i;
   assign lane_full[1]  = y_full_i;
   assign lane_entry[0] = x_entry_i;
   assign lane_entry[1] = y_entry_i;

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         plm_ctx_filter #(
            .DOC_W(DOC_W), .CNT_W(CNT_W), .CTX_HI_W(CTX_HI_W), .CTX_LO_W(CTX_LO_W)
         ) u_filter (
            .entry_i (lane_entry[g]),
            .mask_i  (ctx_mask_i),
            .keep_o  (lane_keep[g])
         );

         assign lane_take[g] = lane_full[g] & ~hold_full[g] & ~halted_q;

         plm_hold #(.WIDTH(ENTRY_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (lane_take[g] & lane_keep[g]),
            .clr_i  (hold_clr[g]),
            .d_i    (lane_entry[g]),
            .full_o (hold_full[g]),
            .q_o    (hold_q[g])
         );

         assign hold_end[g] = hold_full[g] & (&hold_q[g][DOC_TOP -: DOC_W]);
      end
   endgenerate

   plm_combine #(
      .DOC_W(DOC_W), .CNT_W(CNT_W), .CTX_HI_W(CTX_HI_W),
      .CTX_LO_W(CTX_LO_W), .SATURATE(SATURATE)
   ) u_combine (
      .op_i    (op_eff),
      .x_i     (hold_q[0]),
      .y_i     (hold_q[1]),
      .x_low_o (x_low),
      .y_low_o (y_low),
      .emit_o  (emit),
      .out_o   (merged)
   );

   always_comb begin
      unique case (op_eff)
         OP_AND:    term = |hold_end;
         OP_ANDNOT: term = hold_end[0];
         default:   term = &hold_end;
      endcase
      cmp_go      = (&hold_full) & ~term & ~o_full_q & ~halted_q;
      finish      = term & ~o_full_q & ~halted_q;
      hold_clr[0] = cmp_go & x_low;
      hold_clr[1] = cmp_go & y_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q  <= 1'b0;
         o_full_q  <= 1'b0;
         o_entry_q <= '0;
      end else begin
         if (finish) halted_q <= 1'b1;
         if (cmp_go && emit) begin
            o_full_q  <= 1'b1;
            o_entry_q <= merged;
         end else if (o_clr_i) begin
            o_full_q  <= 1'b0;
         end
      end
   end

   assign x_take_o  = lane_take[0];
   assign y_take_o  = lane_take[1];
   assign o_full_o  = o_full_q;
   assign o_entry_o = o_entry_q;
   assign done_o    = finish;
endmodule

// File: rtl/plm_merge_chk.sv
`timescale 1ns/1ps
module plm_merge_chk #(
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CTX_HI_W = 4,
   parameter int unsigned CTX_LO_W = 9
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [1:0]                      op_i,
   input logic                            x_full_i,
   input logic                            x_take_o,
   input logic                            y_full_i,
   input logic                            y_take_o,
   input logic                            o_full_o,
   input logic [2*(1+CTX_LO_W+CNT_W)-1:0] o_entry_o,
   input logic                            o_clr_i,
   input logic                            done_o
);
   localparam int unsigned ENTRY_W = 2 * (1 + CTX_LO_W + CNT_W);

   logic seen_done_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_done_q <= 1'b0;
      else if (done_o) seen_done_q <= 1'b1;
   end

   // R7
   x_take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x_take_o |-> x_full_i);
   // R7
   y_take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      y_take_o |-> y_full_i);
   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_full_o && !o_clr_i) |=> (o_full_o && $stable(o_entry_o)));
   // R10
   done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !o_full_o);
   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_done_q |-> (!x_take_o && !y_take_o && !o_full_o && !done_o));
   // R3
   and_ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(o_full_o) && op_i == 2'b00) |->
         (o_entry_o[ENTRY_W-1 -: CTX_HI_W] == '0 && o_entry_o[CNT_W +: CTX_LO_W] == '0));
endmodule

bind plm_merge_top plm_merge_chk #(
   .CNT_W(CNT_W), .CTX_HI_W(CTX_HI_W), .CTX_LO_W(CTX_LO_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .op_i(op_i),
   .x_full_i(x_full_i), .x_take_o(x_take_o),
   .y_full_i(y_full_i), .y_take_o(y_take_o),
   .o_full_o(o_full_o), .o_entry_o(o_entry_o), .o_clr_i(o_clr_i),
   .done_o(done_o)
);

// File: tb/plm_merge_top_tb.sv
`timescale 1ns/1ps
module plm_merge_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [12:0] ctx_mask_i = '1;
   logic        x_full_i = 1'b0, y_full_i = 1'b0, o_clr_i = 1'b0;
   logic [31:0] x_entry_i = '0, y_entry_i = '0;
   logic        x_take_o, y_take_o, o_full_o, done_o;
   logic [31:0] o_entry_o;

   int checks = 0, failures = 0;
   logic [31:0] xl_mem [64];
   logic [31:0] yl_mem [64];
   logic [31:0] exp_q  [128];
   int nx, ny, nexp;

   always #5 clk = ~clk;

   plm_merge_top dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .ctx_mask_i(ctx_mask_i),
      .x_full_i(x_full_i), .x_entry_i(x_entry_i), .x_take_o(x_take_o),
      .y_full_i(y_full_i), .y_entry_i(y_entry_i), .y_take_o(y_take_o),
      .o_full_o(o_full_o), .o_entry_o(o_entry_o), .o_clr_i(o_clr_i),
      .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit kept(input logic [31:0] e, input logic [12:0] m);
      return (e[27:16] == 12'hFFF) || (|({e[31:28], e[14:6]} & m));
   endfunction

   function automatic logic [31:0] ref_out(input logic [1:0] op, input logic [31:0] x, y,
                                           input bit xlw, ylw);
      logic [6:0] s;
      logic [5:0] c;
      logic [11:0] d;
      d = xlw ? x[27:16] : y[27:16];
      if (op == 2'b00) begin
         c = (x[5:0] < y[5:0]) ? x[5:0] : y[5:0];
         return {4'h0, d, x[15] | y[15], 9'h0, c};
      end
      s = (xlw ? {1'b0, x[5:0]} : 7'd0) + (ylw ? {1'b0, y[5:0]} : 7'd0);
      c = (s > 7'd63) ? 6'd63 : s[5:0];
      return {(xlw ? x[31:28] : 4'h0) | (ylw ? y[31:28] : 4'h0), d,
              (xlw & x[15]) | (ylw & y[15]),
              (xlw ? x[14:6] : 9'h0) | (ylw ? y[14:6] : 9'h0), c};
   endfunction

   task automatic build_expected();
      logic [31:0] fx [64];
      logic [31:0] fy [64];
      int mx = 0, my = 0, i = 0, j = 0;
      bit xs, ys, xlw, ylw, em;
      for (int k = 0; k < nx; k++) if (kept(xl_mem[k], ctx_mask_i)) begin fx[mx] = xl_mem[k]; mx++; end
      for (int k = 0; k < ny; k++) if (kept(yl_mem[k], ctx_mask_i)) begin fy[my] = yl_mem[k]; my++; end
      nexp = 0;
      while (1) begin
         xs = (fx[i][27:16] == 12'hFFF);
         ys = (fy[j][27:16] == 12'hFFF);
         if (op_i == 2'b00 && (xs || ys)) break;
         if (op_i == 2'b10 && xs) break;
         if (op_i[0] && xs && ys) break;
         xlw = fx[i][27:16] <= fy[j][27:16];
         ylw = fy[j][27:16] <= fx[i][27:16];
         em  = (op_i == 2'b00) ? (xlw && ylw) : (op_i == 2'b10) ? (xlw && !ylw) : 1'b1;
         if (em) begin exp_q[nexp] = ref_out(op_i, fx[i], fy[j], xlw, ylw); nexp++; end
         if (xlw) i++;
         if (ylw) j++;
      end
   endtask

   function automatic logic [31:0] mk(input logic [11:0] d, input logic [12:0] ctx,
                                      input bit tg, input logic [5:0] c);
      return {ctx[12:9], d, tg, ctx[8:0], c};
   endfunction

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'b00: return "R3";
         2'b10: return "R5";
         2'b11: return "R12";
         default: return "R4";
      endcase
   endfunction

   task automatic run_case(input int pstall);
      int xi = 0, yi = 0, got = 0, dones = 0, cyc = 0;
      bit xp = 0, yp = 0;
      build_expected();
      x_full_i = 0; y_full_i = 0; o_clr_i = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1;
      // R11 reset state
      check(!o_full_o && !done_o && !x_take_o && !y_take_o, "R11",
            {28'd0, o_full_o, done_o, x_take_o, y_take_o}, 32'd0);
      while (dones == 0 && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (xp) begin xi++; xp = 0; x_full_i = 0; end
         if (yp) begin yi++; yp = 0; y_full_i = 0; end
         if (!x_full_i && xi < nx && $urandom_range(0, 99) >= pstall) begin x_full_i = 1; x_entry_i = xl_mem[xi]; end
         if (!y_full_i && yi < ny && $urandom_range(0, 99) >= pstall) begin y_full_i = 1; y_entry_i = yl_mem[yi]; end
         o_clr_i = 0;
         #1;
         if (x_take_o) xp = 1;
         if (y_take_o) yp = 1;
         if (done_o) begin
            dones++;
            // R10 done only after the output drained
            check(!o_full_o, "R10", {31'd0, o_full_o}, 32'd0);
         end
         if (o_full_o && $urandom_range(0, 99) >= pstall) begin
            if (got < nexp)
               check(o_entry_o === exp_q[got], op_req(op_i), o_entry_o, exp_q[got]);
            else
               check(1'b0, "R2", o_entry_o, 32'hFFFF_FFFF);
            got++;
            o_clr_i = 1;
         end
      end
      check(dones == 1, "R10", dones, 1);
      // R9: after the end no take and no further output
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         o_clr_i = 0;
         if (xp) begin xi++; xp = 0; x_full_i = (xi < nx); x_entry_i = xl_mem[xi % 64]; end
         if (yp) begin yi++; yp = 0; y_full_i = (yi < ny); y_entry_i = yl_mem[yi % 64]; end
         #1;
         check(!x_take_o && !y_take_o && !o_full_o && !done_o, "R9",
               {28'd0, x_take_o, y_take_o, o_full_o, done_o}, 32'd0);
      end
      check(got == nexp, "R9", got, nexp);
   endtask

   task automatic gen_random();
      int d = 0;
      logic [12:0] c;
      nx = 0; ny = 0;
      while (nx < 30 && ny < 30) begin
         d += $urandom_range(1, 5);
         if (d > 4094) break;
         for (int l = 0; l < 2; l++) begin
            int r;
            r = $urandom_range(0, 99);
            c = ($urandom_range(0, 3) == 0) ? 13'd0 : 13'($urandom);
            if (r < 45) begin
               logic [5:0] cn;
               cn = ($urandom_range(0, 4) == 0) ? 6'd63 : 6'($urandom);
               if (l == 0) begin xl_mem[nx] = mk(12'(d), c, 1'($urandom), cn); nx++; end
               else        begin yl_mem[ny] = mk(12'(d), c, 1'($urandom), cn); ny++; end
            end
         end
      end
      xl_mem[nx] = mk(12'hFFF, 13'd0, 1'b0, 6'd0); nx++;
      yl_mem[ny] = mk(12'hFFF, 13'd0, 1'b0, 6'd0); ny++;
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] s;
      s = $urandom(32'd1234);
      // R6 + R4: overlapping counts saturate
      op_i = 2'b01; ctx_mask_i = '1;
      xl_mem[0] = mk(12'd5, 13'h001, 1'b0, 6'd40); xl_mem[1] = mk(12'hFFF, 0, 0, 0); nx = 2;
      yl_mem[0] = mk(12'd5, 13'h100, 1'b1, 6'd40); yl_mem[1] = mk(12'hFFF, 0, 0, 0); ny = 2;
      run_case(0);
      check(exp_q[0][5:0] == 6'd63, "R6", exp_q[0], 32'd63);
      // R3: intersection min count, tag OR, context cleared
      op_i = 2'b00;
      xl_mem[0] = mk(12'd3, 13'h1FFF, 1'b1, 6'd9); xl_mem[1] = mk(12'd7, 13'h2, 0, 6'd1);
      xl_mem[2] = mk(12'hFFF, 0, 0, 0); nx = 3;
      yl_mem[0] = mk(12'd3, 13'h4, 1'b0, 6'd2); yl_mem[1] = mk(12'hFFF, 0, 0, 0); ny = 2;
      run_case(20);
      // R1: entries without a masked flag are dropped
      op_i = 2'b01; ctx_mask_i = 13'h0F0;
      xl_mem[0] = mk(12'd2, 13'h00F, 0, 6'd1); xl_mem[1] = mk(12'd4, 13'h010, 0, 6'd2);
      xl_mem[2] = mk(12'hFFF, 0, 0, 0); nx = 3;
      yl_mem[0] = mk(12'd4, 13'h100, 1, 6'd3); yl_mem[1] = mk(12'hFFF, 0, 0, 0); ny = 2;
      run_case(10);
      // R9: empty first list ends intersection and difference at once
      ctx_mask_i = '1;
      for (int o = 0; o < 4; o++) begin
         op_i = 2'(o);
         xl_mem[0] = mk(12'hFFF, 0, 0, 0); nx = 1;
         for (int k = 0; k < 6; k++) yl_mem[k] = mk(12'(k + 1), 13'h1, 0, 6'(k)); yl_mem[6] = mk(12'hFFF, 0, 0, 0); ny = 7;
         run_case(0);
      end
      // R5: second list empty, difference passes the first list through
      op_i = 2'b10;
      for (int k = 0; k < 5; k++) xl_mem[k] = mk(12'(10 * k + 1), 13'h3, 1'(k), 6'(k)); xl_mem[5] = mk(12'hFFF, 0, 0, 0); nx = 6;
      yl_mem[0] = mk(12'hFFF, 0, 0, 0); ny = 1;
      run_case(30);
      // R2 and all operations under random lists
      for (int t = 0; t < 40; t++) begin
         op_i = 2'($urandom_range(0, 3));
         ctx_mask_i = ($urandom_range(0, 2) == 0) ? 13'h1FFF : 13'($urandom);
         gen_random();
         run_case($urandom_range(0, 60));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule